// File: doc/BRIEF.md
# Virtualized Time Register Unit

This block is one slice of a hart's control-register file. It serves two read-only time registers and a 64-bit guest time offset. The offset is split into a low and a high half when the register width is 32. Reads of the time registers return the platform time. When the hart runs a virtualized guest, the offset is added to that time, so the guest sees its own shifted clock without any help from software. The block has no timer of its own. The platform supplies the running time value and a flag that says whether a time source exists at all.

The access port carries the usual signals: a 12-bit register address, read and write strobes, write data and a privilege level. Read data comes back combinationally in the same cycle. An illegal-access flag tells the trap logic to raise an exception. If no time source is present, every time-related register faults. This lets a software monitor emulate the registers instead. The block is built with a register width parameter of 32 or 64.

Top module: `vtime_csr_unit`

## Requirements
- R1: A read of address 0xC01 returns the low XLEN bits of platform time plus the offset when `virt_i` is high, and of platform time alone when `virt_i` is low.
- R2: With XLEN 32, a read of 0xC81 returns bits 63:32 of the same 64-bit sum, including any carry out of bit 31.
- R3: With XLEN 64, address 0x605 reads and writes the whole 64-bit offset.
- R4: With XLEN 32, a write to 0x605 replaces offset bits 31:0 and keeps bits 63:32. A write to 0x615 replaces bits 63:32 and keeps bits 31:0.
- R5: With XLEN 32, a read of 0x605 returns offset bits 31:0, and a read of 0x615 returns bits 63:32.
- R6: When `time_valid_i` is low, any read or write of 0xC01, 0xC81, 0x605 or 0x615 raises `csr_illegal_o`, returns zero read data and leaves the offset unchanged.
- R7: The offset registers (0x605 and 0x615) need hypervisor rights. These are held at `priv_i` 2'b11, or at `priv_i` 2'b01 with `virt_i` low. Any other access faults, returns zero and leaves the offset unchanged.
- R8: The time registers (0xC01 and 0xC81) are legal only when `priv_i` is 2'b11 or `cnt_en_i` is high. Otherwise they fault and return zero.
- R9: With XLEN 64, any access to 0xC81 or 0x615 faults.
- R10: A write strobe to 0xC01 or 0xC81 faults, because the time registers are read-only.
- R11: The offset is zero after reset. A legal write becomes visible on reads after the next rising clock edge, and read data is combinational.
- R12: An access to any other address leaves `csr_illegal_o` low, returns zero and does not change the offset. Without a read strobe, `csr_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| plat_time_i | input | 64 | Running platform time |
| time_valid_i | input | 1 | A platform time source exists |
| virt_i | input | 1 | Hart runs in virtualized guest mode |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| cnt_en_i | input | 1 | Counter-enable permission for the time registers |
| csr_addr_i | input | 12 | Register address |
| csr_rd_i | input | 1 | Read strobe |
| csr_wr_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, combinational |
| csr_illegal_o | output | 1 | Access faults |

## Verification
The assertions assume that the access inputs are held steady between rising edges. They also assume `time_valid_i` is a known level, since a fault depends on it in the same cycle. The offset-stability properties compare the offset across one edge. The bench therefore changes its inputs only at falling edges, which gives exactly one access per cycle. Stimulus mixes directed cases with random ones. The directed cases cover the carry into the high half, the reserved privilege encoding, missing time source, and writes to read-only registers. The random cases use a mix of valid and stray addresses. Two instances, at widths 32 and 64, see the same stimulus.

// File: rtl/vtime_pkg.sv
`timescale 1ns/1ps
package vtime_pkg;
  localparam logic [11:0] ADDR_TIME   = 12'hC01;
  localparam logic [11:0] ADDR_TIMEH  = 12'hC81;
  localparam logic [11:0] ADDR_TDLT   = 12'h605;
  localparam logic [11:0] ADDR_TDLTH  = 12'h615;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  typedef struct packed {
    logic time_lo;
    logic time_hi;
    logic dlt_lo;
    logic dlt_hi;
  } sel_t;
endpackage

// File: rtl/vtime_access_check.sv
`timescale 1ns/1ps
module vtime_access_check
  import vtime_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        src_ok_i,
  input  logic        virt_i,
  input  logic [1:0]  priv_i,
  input  logic        cnt_en_i,
  output sel_t        sel_o,
  output logic        illegal_o
);
  localparam bit HasHi = (XLEN == 32);

  logic m_time, m_timeh, m_dlt, m_dlth;
  logic is_time, is_hi, known, access;
  logic h_rights, t_rights, bad;
  priv_e priv;

  always_comb begin
    priv     = priv_e'(priv_i);
    m_time   = (addr_i == ADDR_TIME);
    m_timeh  = (addr_i == ADDR_TIMEH);
    m_dlt    = (addr_i == ADDR_TDLT);
    m_dlth   = (addr_i == ADDR_TDLTH);
    is_time  = m_time | m_timeh;
    is_hi    = m_timeh | m_dlth;
    known    = is_time | m_dlt | m_dlth;
    access   = rd_i | wr_i;
    h_rights = (priv == PRIV_M) || ((priv == PRIV_S) && !virt_i);
    t_rights = (priv == PRIV_M) || cnt_en_i;
    bad      = !src_ok_i
             | (is_time & (!t_rights | wr_i))
             | (!is_time & !h_rights)
             | (is_hi & !HasHi);
    illegal_o = access & known & bad;
    sel_o.time_lo = access & !bad & m_time;
    sel_o.time_hi = access & !bad & m_timeh;
    sel_o.dlt_lo  = access & !bad & m_dlt;
    sel_o.dlt_hi  = access & !bad & m_dlth;
  end
endmodule

// File: rtl/vtime_offset_reg.sv
`timescale 1ns/1ps
module vtime_offset_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [63:0]     delta_o
);
  logic [63:0] delta_q;

  generate
    if (XLEN == 64) begin : g_full
      // high-half strobe is never decoded at this width
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 delta_q <= '0;
        else if (wr_lo_i || wr_hi_i) delta_q <= 64'(wdata_i);
      end
    end else begin : g_split
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          delta_q <= '0;
        end else begin
          if (wr_lo_i) delta_q[31:0]  <= wdata_i[31:0];
          if (wr_hi_i) delta_q[63:32] <= wdata_i[31:0];
        end
      end
    end
  endgenerate

  assign delta_o = delta_q;
endmodule

// File: rtl/vtime_csr_unit.sv
`timescale 1ns/1ps
module vtime_csr_unit
  import vtime_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [63:0]     plat_time_i,
  input  logic            time_valid_i,
  input  logic            virt_i,
  input  logic [1:0]      priv_i,
  input  logic            cnt_en_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_rd_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o
);
  sel_t        sel;
  logic [63:0] delta, sum, rd_word;

  vtime_access_check #(.XLEN(XLEN)) u_check (
    .addr_i    (csr_addr_i),
    .rd_i      (csr_rd_i),
    .wr_i      (csr_wr_i),
    .src_ok_i  (time_valid_i),
    .virt_i    (virt_i),
    .priv_i    (priv_i),
    .cnt_en_i  (cnt_en_i),
    .sel_o     (sel),
    .illegal_o (csr_illegal_o)
  );

  vtime_offset_reg #(.XLEN(XLEN)) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (sel.dlt_lo & csr_wr_i),
    .wr_hi_i (sel.dlt_hi & csr_wr_i),
    .wdata_i (csr_wdata_i),
    .delta_o (delta)
  );

  assign sum = plat_time_i + (virt_i ? delta : 64'd0);

  always_comb begin
    rd_word = '0;
    if (csr_rd_i) begin
      unique case (1'b1)
        sel.time_lo: rd_word = sum;
        sel.time_hi: rd_word = {32'd0, sum[63:32]};
        sel.dlt_lo:  rd_word = delta;
        sel.dlt_hi:  rd_word = {32'd0, delta[63:32]};
        default:     rd_word = '0;
      endcase
    end
    csr_rdata_o = rd_word[XLEN-1:0];
  end

  logic known_addr;
  assign known_addr = (csr_addr_i == ADDR_TIME) || (csr_addr_i == ADDR_TIMEH) ||
                      (csr_addr_i == ADDR_TDLT) || (csr_addr_i == ADDR_TDLTH);

  assert_no_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_rd_i || csr_wr_i) && known_addr && !time_valid_i)
      |-> (csr_illegal_o && csr_rdata_o == '0));

  assert_time_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && (csr_addr_i == ADDR_TIME || csr_addr_i == ADDR_TIMEH)) |-> csr_illegal_o);

  assert_fault_keeps_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && (csr_illegal_o || !known_addr)) |=> $stable(delta));

  assert_fault_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == '0));

  generate
    if (XLEN == 64) begin : g_chk64
      assert_no_high_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((csr_rd_i || csr_wr_i) && (csr_addr_i == ADDR_TIMEH || csr_addr_i == ADDR_TDLTH))
          |-> csr_illegal_o);
    end else begin : g_chk32
      assert_low_write_keeps_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_wr_i && csr_addr_i == ADDR_TDLT)
          |=> (delta[63:32] == $past(delta[63:32])));
      assert_high_write_keeps_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_wr_i && csr_addr_i == ADDR_TDLTH)
          |=> (delta[31:0] == $past(delta[31:0])));
    end
  endgenerate
endmodule

// File: tb/vtime_csr_unit_bench.sv
`timescale 1ns/1ps
module vtime_csr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] plat_time = '0;
  logic        time_valid = 1'b0;
  logic        virt = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic        cnt_en = 1'b0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [31:0] rdata32;
  logic [63:0] rdata64;
  logic        ill32, ill64;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] ref_d32 = '0;
  logic [63:0] ref_d64 = '0;

  always #10 clk = ~clk;

  vtime_csr_unit #(.XLEN(32)) u_vtime_csr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .plat_time_i(plat_time), .time_valid_i(time_valid),
    .virt_i(virt), .priv_i(priv), .cnt_en_i(cnt_en), .csr_addr_i(addr),
    .csr_rd_i(rd), .csr_wr_i(wr), .csr_wdata_i(wdata[31:0]),
    .csr_rdata_o(rdata32), .csr_illegal_o(ill32));

  vtime_csr_unit #(.XLEN(64)) u_vtime_csr_unit_w64 (
    .clk_i(clk), .rst_ni(rst_ni), .plat_time_i(plat_time), .time_valid_i(time_valid),
    .virt_i(virt), .priv_i(priv), .cnt_en_i(cnt_en), .csr_addr_i(addr),
    .csr_rd_i(rd), .csr_wr_i(wr), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata64), .csr_illegal_o(ill64));

  // behavioural model of one access, straight from the requirements
  function automatic void model(input int xl, input logic [63:0] d,
                                output logic ill, output logic [63:0] rv,
                                output logic [63:0] nd, output string tag);
    logic known, is_t, hi, hr, tr, bad, ok;
    logic [63:0] sum;
    known = addr inside {12'hC01, 12'hC81, 12'h605, 12'h615};
    is_t  = addr inside {12'hC01, 12'hC81};
    hi    = addr inside {12'hC81, 12'h615};
    hr    = (priv == 2'b11) || (priv == 2'b01 && !virt);
    tr    = (priv == 2'b11) || cnt_en;
    bad   = !time_valid || (is_t && (!tr || wr)) || (!is_t && !hr) || (hi && xl == 64);
    ill   = (rd || wr) && known && bad;
    ok    = (rd || wr) && known && !bad;
    sum   = plat_time + (virt ? d : 64'd0);
    rv = '0;
    nd = d;
    if (ok && rd) begin
      case (addr)
        12'hC01: rv = (xl == 32) ? {32'd0, sum[31:0]} : sum;
        12'hC81: rv = {32'd0, sum[63:32]};
        12'h605: rv = (xl == 32) ? {32'd0, d[31:0]} : d;
        default: rv = {32'd0, d[63:32]};
      endcase
    end
    if (ok && wr) begin
      if (addr == 12'h605) nd = (xl == 32) ? {d[63:32], wdata[31:0]} : wdata;
      if (addr == 12'h615) nd = {wdata[31:0], d[31:0]};
    end
    if (!known)                            tag = "R12";
    else if (!time_valid)                  tag = "R6";
    else if (is_t && wr)                   tag = "R10";
    else if (hi && xl == 64)               tag = "R9";
    else if (is_t && !tr)                  tag = "R8";
    else if (!is_t && !hr)                 tag = "R7";
    else if (addr == 12'hC01)              tag = "R1";
    else if (addr == 12'hC81)              tag = "R2";
    else if (xl == 64)                     tag = "R3";
    else if (wr)                           tag = "R4";
    else                                   tag = "R5";
  endfunction

  task automatic apply(input logic [11:0] a, input logic r, input logic w,
                       input logic [63:0] wd, input logic v, input logic vi,
                       input logic [1:0] p, input logic ce, input logic [63:0] pt);
    logic e_ill32, e_ill64;
    logic [63:0] e_rv32, e_rv64, n32, n64;
    string t32, t64;
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = wd; time_valid = v; virt = vi;
    priv = p; cnt_en = ce; plat_time = pt;
    #5;
    model(32, ref_d32, e_ill32, e_rv32, n32, t32);
    model(64, ref_d64, e_ill64, e_rv64, n64, t64);
    vectors++;
    if (ill32 !== e_ill32 || rdata32 !== e_rv32[31:0]) begin
      miscompares++;
      $display("FAIL %s x32 addr=%h: got ill=%b data=%h, expected ill=%b data=%h",
               t32, a, ill32, rdata32, e_ill32, e_rv32[31:0]);
    end
    vectors++;
    if (ill64 !== e_ill64 || rdata64 !== e_rv64) begin
      miscompares++;
      $display("FAIL %s x64 addr=%h: got ill=%b data=%h, expected ill=%b data=%h",
               t64, a, ill64, rdata64, e_ill64, e_rv64);
    end
    @(posedge clk);
    ref_d32 = n32;
    ref_d64 = n64;
  endtask

  logic done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R11: offset reads zero right after reset
    apply(12'h605, 1, 0, 0, 1, 0, 2'b11, 0, 64'h1234);
    apply(12'h615, 1, 0, 0, 1, 0, 2'b11, 0, 64'h1234);
    // R1 time without and with offset (offset zero)
    apply(12'hC01, 1, 0, 0, 1, 0, 2'b11, 0, 64'hAAAA_BBBB_CCCC_DDDD);
    // R4/R3 write low half then high half; R11 visible next cycle
    apply(12'h605, 0, 1, 64'h0000_0005_0000_0001, 1, 0, 2'b11, 0, 0);
    apply(12'h605, 1, 0, 0, 1, 0, 2'b11, 0, 0);
    apply(12'h615, 0, 1, 64'h0000_0000_0000_0007, 1, 0, 2'b01, 0, 0);
    apply(12'h615, 1, 0, 0, 1, 0, 2'b01, 0, 0);
    // R2 carry from low half into timeh
    apply(12'hC01, 1, 0, 0, 1, 1, 2'b11, 0, 64'h0000_0010_FFFF_FFFF);
    apply(12'hC81, 1, 0, 0, 1, 1, 2'b11, 0, 64'h0000_0010_FFFF_FFFF);
    apply(12'hC81, 1, 0, 0, 1, 0, 2'b11, 0, 64'h0000_0010_FFFF_FFFF);
    // R8 counter permission
    apply(12'hC01, 1, 0, 0, 1, 0, 2'b00, 0, 64'h55);
    apply(12'hC01, 1, 0, 0, 1, 1, 2'b00, 1, 64'h55);
    // R7 guest supervisor and reserved level have no hypervisor rights
    apply(12'h605, 0, 1, 64'hDEAD, 1, 1, 2'b01, 1, 0);
    apply(12'h605, 1, 1, 64'hBEEF, 1, 0, 2'b10, 1, 0);
    apply(12'h605, 1, 0, 0, 1, 0, 2'b11, 0, 0);
    // R6 no time source
    apply(12'h605, 1, 1, 64'h99, 0, 0, 2'b11, 1, 0);
    apply(12'hC01, 1, 0, 0, 0, 0, 2'b11, 1, 64'h77);
    // R10 write to read-only time registers
    apply(12'hC01, 1, 1, 64'h1, 1, 0, 2'b11, 1, 64'h77);
    apply(12'hC81, 0, 1, 64'h1, 1, 0, 2'b11, 1, 64'h77);
    // R9 high halves at width 64; R12 stray address and no strobe
    apply(12'h615, 1, 0, 0, 1, 0, 2'b11, 1, 0);
    apply(12'h300, 1, 1, 64'h5, 1, 0, 2'b11, 1, 0);
    apply(12'h605, 0, 0, 64'h5, 1, 0, 2'b11, 1, 0);
    apply(12'h605, 1, 0, 0, 1, 0, 2'b11, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 4))
        0: a = 12'hC01;
        1: a = 12'hC81;
        2: a = 12'h605;
        3: a = 12'h615;
        default: a = 12'($urandom);
      endcase
      apply(a, 1'($urandom), 1'($urandom), {$urandom, $urandom},
            ($urandom_range(0, 7) != 0), 1'($urandom), 2'($urandom), 1'($urandom),
            {$urandom, $urandom});
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule